// File: doc/BRIEF.md
# Double-Precision Compare-to-Mask Unit

This unit compares two IEEE-754 double-precision operands, A and B, under one of four predicates and turns the outcome into a 128-bit mask destination value. A true result is a mask with the upper half all ones and the lower half all zeros. A false result is a mask of all zeros. The unit also classifies NaN operands. It reports two invalid-operation conditions as single-cycle pulses: a signaling-NaN flag and an invalid-compare flag for the ordered predicates.

One operation is presented per cycle with `in_valid`. The result, the flags and a write-suppress indication appear registered on the next clock edge. When the invalid-operation enable is set and either invalid condition arises, the unit returns the old destination value unchanged and raises `wr_suppress`. A surrounding datapath can then leave its register file alone and deliver the trap.

Top module: `fp_cmp_mask_unit`

## Requirements
- R1: With `pred_sel` = 0 (equal), the predicate holds when B equals A. +0 and -0 are equal to each other.
- R2: With `pred_sel` = 1 (greater-or-equal), the predicate holds when B is less than or equal to A. With `pred_sel` = 2 (greater-than), it holds when B is less than A. Sign and magnitude order follow IEEE-754, infinities included.
- R3: With `pred_sel` = 3 (not-equal), the predicate holds exactly when the equality test of R1 is false. This includes every case where an operand is a NaN.
- R4: When no write is suppressed, `dst_new` is {64 ones, 64 zeros} if the predicate holds and 128 zeros otherwise. Any NaN operand makes equal, greater-or-equal and greater-than false.
- R5: A NaN has exponent bits [62:52] all ones and a nonzero fraction [51:0]. It is signaling when bit 51 is 0 and quiet when bit 51 is 1. `flag_snan` pulses when either operand is a signaling NaN.
- R6: For greater-or-equal and greater-than, a signaling-NaN operand also pulses `flag_vc`, but only when `inv_en` is 0.
- R7: For greater-or-equal and greater-than with no signaling NaN present, a quiet NaN in either operand pulses `flag_vc`.
- R8: Equal and not-equal never pulse `flag_vc`.
- R9: When `inv_en` is 1 and either flag is raised, `wr_suppress` is 1 and `dst_new` equals the `dst_old` value sampled with the operation. With `inv_en` = 0, `wr_suppress` stays 0.
- R10: The outputs are registered one cycle after a valid input. `out_valid`, `flag_snan`, `flag_vc` and `wr_suppress` are 0 in a cycle that follows no valid input, and `dst_new` holds its last value. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opnd_a | input | 64 | Operand A, double precision |
| opnd_b | input | 64 | Operand B, double precision |
| dst_old | input | 128 | Current destination value |
| pred_sel | input | 2 | 0 equal, 1 greater-or-equal, 2 greater-than, 3 not-equal |
| inv_en | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result registered from a valid input |
| dst_new | output | 128 | New destination value (mask or old value) |
| wr_suppress | output | 1 | Destination left unchanged by an enabled exception |
| flag_snan | output | 1 | Signaling-NaN invalid pulse |
| flag_vc | output | 1 | Invalid-compare pulse |

## Verification
Every result of this unit is due exactly one rising edge after the cycle in which `in_valid` was high. The bench drives each operation on a falling edge and samples the mask, both flags and the suppress bit on the very next falling edge. At that point exactly one register stage has updated. For idle cycles, the bench checks one further falling edge later that the pulses have dropped and that the mask is held. In back-to-back runs, each result is sampled in the half cycle before the following operation can overwrite it.

// File: rtl/fp_cmp_pkg.sv
// Package fp_cmp_pkg
// Shared types for the compare-to-mask unit: predicate encoding and the
// per-operand classification record. Assumes IEEE-754 binary layouts.
package fp_cmp_pkg;

    typedef enum logic [1:0] {
        PRED_EQ = 2'd0,
        PRED_GE = 2'd1,
        PRED_GT = 2'd2,
        PRED_NE = 2'd3
    } pred_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_zero;
    } fp_kind_t;

endpackage

// File: rtl/fp_classify.sv
// Module fp_classify
// Classifies one floating-point operand as NaN (signaling or quiet) or zero.
// Assumes the layout sign | exponent | fraction. The fraction MSB selects
// quiet (1) or signaling (0).
module fp_classify
    import fp_cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fp_kind_t              kind
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = val[EXP_W+FRAC_W-1:FRAC_W];
    assign frac = val[FRAC_W-1:0];

    // Decode the exponent and fraction into class bits.
    always_comb begin
        kind.is_nan  = (&expo) && (|frac);
        kind.is_qnan = kind.is_nan && frac[FRAC_W-1];
        kind.is_snan = kind.is_nan && !frac[FRAC_W-1];
        kind.is_zero = (expo == '0) && (frac == '0);
    end
endmodule

// File: rtl/fp_order.sv
// Module fp_order
// Orders operand x against operand y: x == y, x < y, x <= y.
// Assumes NaN and zero class bits come from fp_classify. Any NaN makes
// all three results false. +0 and -0 compare equal.
module fp_order #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] x,
    input  logic [EXP_W+FRAC_W:0] y,
    input  logic                  nan_x,
    input  logic                  nan_y,
    input  logic                  zero_x,
    input  logic                  zero_y,
    output logic                  x_eq_y,
    output logic                  x_lt_y,
    output logic                  x_le_y
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic           sign_x, sign_y, both_zero, any_nan, raw_eq, raw_lt;
    logic [W-2:0]   mag_x, mag_y;

    assign sign_x    = x[W-1];
    assign sign_y    = y[W-1];
    assign mag_x     = x[W-2:0];
    assign mag_y     = y[W-2:0];
    assign both_zero = zero_x && zero_y;
    assign any_nan   = nan_x || nan_y;

    // Sign-magnitude ordering ignoring NaN.
    always_comb begin
        raw_eq = (x == y) || both_zero;
        if (both_zero)
            raw_lt = 1'b0;
        else if (sign_x != sign_y)
            raw_lt = sign_x;
        else if (!sign_x)
            raw_lt = mag_x < mag_y;
        else
            raw_lt = mag_x > mag_y;
    end

    // Unordered operands make every relation false.
    always_comb begin
        x_eq_y = !any_nan && raw_eq;
        x_lt_y = !any_nan && raw_lt;
        x_le_y = x_eq_y || x_lt_y;
    end
endmodule

// File: rtl/cmp_decide.sv
// Module cmp_decide
// Selects the predicate outcome and derives the invalid flags and the
// write-suppress decision. Assumes the relations are B against A.
module cmp_decide
    import fp_cmp_pkg::*;
(
    input  pred_e pred,
    input  logic  inv_en,
    input  logic  snan_any,
    input  logic  qnan_any,
    input  logic  b_eq_a,
    input  logic  b_lt_a,
    input  logic  b_le_a,
    output logic  hit,
    output logic  raise_snan,
    output logic  raise_vc,
    output logic  suppress
);
    logic ordered;

    assign ordered = (pred == PRED_GE) || (pred == PRED_GT);

    // Invalid-operation flags and the enabled-exception suppress.
    always_comb begin
        raise_snan = snan_any;
        if (!ordered)
            raise_vc = 1'b0;
        else if (snan_any)
            raise_vc = !inv_en;
        else
            raise_vc = qnan_any;
        suppress = inv_en && (raise_snan || raise_vc);
    end

    // Predicate outcome.
    always_comb begin
        unique case (pred)
            PRED_EQ: hit = b_eq_a;
            PRED_GE: hit = b_le_a;
            PRED_GT: hit = b_lt_a;
            PRED_NE: hit = !b_eq_a;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_cmp_mask_unit.sv
// Module fp_cmp_mask_unit
// Compares two floating-point operands and registers a 128-bit mask result,
// two invalid-flag pulses and a write-suppress bit one cycle after in_valid.
// Assumes double precision by default. dst_new holds while idle.
module fp_cmp_mask_unit
    import fp_cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [EXP_W+FRAC_W:0]        opnd_a,
    input  logic [EXP_W+FRAC_W:0]        opnd_b,
    input  logic [2*(EXP_W+FRAC_W+1)-1:0] dst_old,
    input  logic [1:0]                   pred_sel,
    input  logic                         inv_en,
    output logic                         out_valid,
    output logic [2*(EXP_W+FRAC_W+1)-1:0] dst_new,
    output logic                         wr_suppress,
    output logic                         flag_snan,
    output logic                         flag_vc
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int RES_W = 2 * W;
    localparam logic [RES_W-1:0] TRUE_MASK = {{W{1'b1}}, {W{1'b0}}};

    logic [W-1:0] opnd [2];
    fp_kind_t     kind [2];
    logic         b_eq_a, b_lt_a, b_le_a;
    logic         hit, raise_snan, raise_vc, suppress;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    for (genvar g = 0; g < 2; g++) begin : g_class
        fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
            .val  (opnd[g]),
            .kind (kind[g])
        );
    end

    fp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
        .x      (opnd_b),
        .y      (opnd_a),
        .nan_x  (kind[1].is_nan),
        .nan_y  (kind[0].is_nan),
        .zero_x (kind[1].is_zero),
        .zero_y (kind[0].is_zero),
        .x_eq_y (b_eq_a),
        .x_lt_y (b_lt_a),
        .x_le_y (b_le_a)
    );

    cmp_decide u_decide (
        .pred       (pred_e'(pred_sel)),
        .inv_en     (inv_en),
        .snan_any   (kind[0].is_snan || kind[1].is_snan),
        .qnan_any   (kind[0].is_qnan || kind[1].is_qnan),
        .b_eq_a     (b_eq_a),
        .b_lt_a     (b_lt_a),
        .b_le_a     (b_le_a),
        .hit        (hit),
        .raise_snan (raise_snan),
        .raise_vc   (raise_vc),
        .suppress   (suppress)
    );

    // Output stage: pulses qualified by in_valid, destination held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            flag_snan   <= 1'b0;
            flag_vc     <= 1'b0;
            wr_suppress <= 1'b0;
            dst_new     <= '0;
        end else begin
            out_valid   <= in_valid;
            flag_snan   <= in_valid && raise_snan;
            flag_vc     <= in_valid && raise_vc;
            wr_suppress <= in_valid && suppress;
            if (in_valid)
                dst_new <= suppress ? dst_old : (hit ? TRUE_MASK : '0);
        end
    end
endmodule

// File: rtl/fp_cmp_mask_unit_chk.sv
// Module fp_cmp_mask_unit_chk
// Property checker for fp_cmp_mask_unit, attached by bind below.
// Assumes the same parameters as the unit it observes.
module fp_cmp_mask_unit_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [EXP_W+FRAC_W:0]         opnd_a,
    input logic [EXP_W+FRAC_W:0]         opnd_b,
    input logic [2*(EXP_W+FRAC_W+1)-1:0] dst_old,
    input logic [1:0]                    pred_sel,
    input logic                          inv_en,
    input logic                          out_valid,
    input logic [2*(EXP_W+FRAC_W+1)-1:0] dst_new,
    input logic                          wr_suppress,
    input logic                          flag_snan,
    input logic                          flag_vc
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int RES_W = 2 * W;

    logic a_sig, b_sig, sig_in, ordered_in;

    // Independent signaling-NaN recognition on the raw operands.
    assign a_sig = (&opnd_a[W-2:FRAC_W]) && (opnd_a[FRAC_W-2:0] != '0) && !opnd_a[FRAC_W-1];
    assign b_sig = (&opnd_b[W-2:FRAC_W]) && (opnd_b[FRAC_W-2:0] != '0) && !opnd_b[FRAC_W-1];
    assign sig_in     = a_sig || b_sig;
    assign ordered_in = (pred_sel == 2'd1) || (pred_sel == 2'd2);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !flag_snan && !flag_vc && !wr_suppress);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst_new));

    p_mask_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !wr_suppress |->
            (dst_new[W-1:0] == '0) &&
            ((dst_new[RES_W-1:W] == '0) || (&dst_new[RES_W-1:W])));

    p_snan_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sig_in |=> flag_snan);

    p_snan_vc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sig_in && ordered_in && !inv_en |=> flag_vc);

    p_eq_ne_no_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ordered_in |=> !flag_vc);

    p_no_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !inv_en |=> !wr_suppress);

    p_keep_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && inv_en && sig_in |=> wr_suppress && (dst_new == $past(dst_old)));
endmodule

bind fp_cmp_mask_unit fp_cmp_mask_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (.*);

// File: tb/fp_cmp_mask_unit_tb_top.sv
// Bench fp_cmp_mask_unit_tb_top
// Walks a table of operand/predicate vectors, then runs directed tests
// for reset, idle behaviour and back-to-back operations.
module fp_cmp_mask_unit_tb_top;

    localparam logic [63:0] P1   = 64'h3FF0_0000_0000_0000; // +1.0
    localparam logic [63:0] P2   = 64'h4000_0000_0000_0000; // +2.0
    localparam logic [63:0] M1   = 64'hBFF0_0000_0000_0000; // -1.0
    localparam logic [63:0] M2   = 64'hC000_0000_0000_0000; // -2.0
    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000; // +0
    localparam logic [63:0] MZ   = 64'h8000_0000_0000_0000; // -0
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] MINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0001;
    localparam logic [127:0] MASK = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  p;
        logic        ie;
        logic        hit;
        logic        sn;
        logic        vc;
        logic        sup;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{P1,   P1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 equal
        '{PZ,   MZ, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 signed zeros
        '{P1,   P2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 unequal
        '{P2,   P1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 ge
        '{P1,   P1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 ge equal
        '{P1,   P2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 ge false
        '{P1,   P1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 gt equal
        '{P2,   P1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 gt
        '{M1,   M2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 negatives
        '{M2,   M1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 negatives false
        '{P1,   M1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 mixed signs
        '{PINF, P1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 infinity
        '{MINF, PZ, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 -inf
        '{P1,   P2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 ne
        '{P1,   P1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 ne false
        '{QN,   P1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 ne NaN
        '{QN,   P1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 R8 eq NaN
        '{QN,   P1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 qnan ge
        '{P1,   QN, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 R9 qnan gt enabled
        '{SN,   P1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 R6 snan ge
        '{SN,   P1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 R9 snan gt enabled
        '{P1,   SN, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 R8 snan eq
        '{P1,   SN, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 R9 snan ne enabled
        '{SN,   P1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 R5 snan ne
        '{QN,   P1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 R9 qnan eq enabled
        '{PZ,   MZ, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 R2 zeros ge
        '{MZ,   PZ, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R1 R2 zeros gt
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  opnd_a = '0, opnd_b = '0;
    logic [127:0] dst_old = '0;
    logic [1:0]   pred_sel = '0;
    logic         inv_en = 1'b0;
    logic         out_valid, wr_suppress, flag_snan, flag_vc;
    logic [127:0] dst_new;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fp_cmp_mask_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .dst_old     (dst_old),
        .pred_sel    (pred_sel),
        .inv_en      (inv_en),
        .out_valid   (out_valid),
        .dst_new     (dst_new),
        .wr_suppress (wr_suppress),
        .flag_snan   (flag_snan),
        .flag_vc     (flag_vc)
    );

    task automatic expect_val(string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive(logic [63:0] a, logic [63:0] b, logic [1:0] p,
                         logic ie, logic [127:0] old);
        opnd_a = a; opnd_b = b; pred_sel = p; inv_en = ie; dst_old = old;
        in_valid = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual timeout expected finish");
        finish_run();
    end

    initial begin
        logic [127:0] old;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        expect_val("R10 reset out_valid", 128'(out_valid), 128'd0);
        expect_val("R10 reset dst_new", dst_new, 128'd0);
        expect_val("R10 reset flags", {126'd0, flag_snan, flag_vc}, 128'd0);
        expect_val("R10 reset wr_suppress", 128'(wr_suppress), 128'd0);

        // Table walk: one operation, sampled one edge later.
        for (int i = 0; i < NV; i++) begin
            old = {64'hDEAD_BEEF_0000_0000 | 64'(i), 64'h1234_5678_9ABC_DEF0};
            drive(VECS[i].a, VECS[i].b, VECS[i].p, VECS[i].ie, old);
            @(negedge clk);
            in_valid = 1'b0;
            expect_val($sformatf("vec %0d dst R1 R2 R3 R4 R9", i), dst_new,
                       VECS[i].sup ? old : (VECS[i].hit ? MASK : 128'd0));
            expect_val($sformatf("vec %0d flag_snan R5", i), 128'(flag_snan), 128'(VECS[i].sn));
            expect_val($sformatf("vec %0d flag_vc R6 R7 R8", i), 128'(flag_vc), 128'(VECS[i].vc));
            expect_val($sformatf("vec %0d wr_suppress R9", i), 128'(wr_suppress), 128'(VECS[i].sup));
            expect_val($sformatf("vec %0d out_valid R10", i), 128'(out_valid), 128'd1);
        end

        // R10: idle after a flagged op clears pulses and holds dst_new.
        drive(SN, P1, 2'd1, 1'b0, 128'd7);
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a = P1; opnd_b = P1; pred_sel = 2'd0;
        @(negedge clk);
        expect_val("R10 idle pulses", {125'd0, out_valid, flag_snan, flag_vc}, 128'd0);
        expect_val("R10 idle suppress", 128'(wr_suppress), 128'd0);
        expect_val("R10 idle dst held", dst_new, 128'd0);

        // R10 R2 R1: back-to-back operations.
        drive(P2, P1, 2'd2, 1'b0, 128'd1);
        @(negedge clk);
        expect_val("R2 b2b first dst", dst_new, MASK);
        drive(P1, P2, 2'd0, 1'b0, 128'd2);
        @(negedge clk);
        in_valid = 1'b0;
        expect_val("R1 b2b second dst", dst_new, 128'd0);
        expect_val("R10 b2b second valid", 128'(out_valid), 128'd1);

        // R9: enabled quiet-NaN compare keeps old value, then normal op writes.
        drive(QN, QN, 2'd1, 1'b1, {64'h0, 64'hCAFE});
        @(negedge clk);
        expect_val("R9 keep old", dst_new, {64'h0, 64'hCAFE});
        drive(M1, M1, 2'd1, 1'b1, {64'h0, 64'hCAFE});
        @(negedge clk);
        in_valid = 1'b0;
        expect_val("R9 normal write after suppress", dst_new, MASK);
        expect_val("R9 no suppress", 128'(wr_suppress), 128'd0);

        finish_run();
    end
endmodule